// File: doc/BRIEF.md
# Linear CCD Clock Timing Generator

This block derives every drive clock of a three-colour linear CCD from one fast system clock. The clocks are a readout-gate strobe and a shutter drain pulse per colour, two complementary transfer phases, a last-stage hold clock and a reset clock. A single-cycle start strobe launches a line. The block first holds the transfer phases still around the readout gate. It then clocks out a fixed number of pixels, and finally releases each colour's shutter at its own programmed point. A line-valid flag and a pixel index let downstream capture logic pick up each sample.

Every interval is a parameter counted in system clocks. Elaboration checks compare those counts against the sensor's minimum times, using the system clock period parameter. Release counts are given per colour, in pixel periods after the last pixel of the line. A later release shortens the time between the shutter opening and the next readout gate, so it shortens that colour's integration time. A start strobe that arrives while a line is busy is remembered and serviced after the line.

Top module: `lccd_timing_gen`

## Requirements
- R1: After a line begins, `o_line_valid` is high for exactly LINE_PIXELS × PIX_CLKS cycles. During that window the transfer phase completes exactly LINE_PIXELS periods. At each rising edge of `o_rst_pulse` inside the window, `o_pix_idx` holds the pixel number, counting 1, 2, … LINE_PIXELS.
- R2: All colour bits of `o_gate` rise and fall together, once per line, and stay high for exactly T_GATE cycles.
- R3: `o_phi1` is high and unchanged when the gates rise. The first falling edge of `o_phi1` comes exactly T_SETTLE + PIX_CLKS/2 cycles after the gates fall.
- R4: `o_phi2` is always the complement of `o_phi1`, and `o_hold` always equals `o_phi1`. Within a line, `o_phi1` falls every PIX_CLKS cycles, with its high half first.
- R5: `o_rst_pulse` rises exactly RS_GAP cycles after `o_hold` falls and stays high for exactly RS_HIGH cycles.
- R6: A start strobe that arrives while a line is busy (gate, readout or shutter release still pending) starts exactly one further line. That line's gates rise T_SETUP + 1 cycles after the last shutter of the previous line falls. Further strobes in the same busy line add no more lines.
- R7: Each shutter bit rises together with the gates and stays high through the whole valid window. Colour c falls exactly release[c] × PIX_CLKS cycles after `o_line_valid` falls. Colour c occupies bits c×REL_W upward in `i_release` (0 = red, 1 = green, 2 = blue).
- R8: Release counts are sampled when a line is launched. Changing `i_release` later in that line has no effect on its shutter falls.
- R9: After reset, and between lines, `o_phi1` and `o_hold` are high. `o_phi2`, `o_rst_pulse`, `o_gate`, `o_shut` and `o_line_valid` are low, and `o_pix_idx` is 0. Without a start strobe no gate pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_start | input | 1 | Line start strobe, one cycle |
| i_release | input | NCOL×REL_W | Per-colour shutter release counts in pixel periods |
| o_gate | output | NCOL | Readout-gate pulses, one per colour |
| o_shut | output | NCOL | Shutter drain pulses, one per colour |
| o_phi1 | output | 1 | Transfer phase 1 |
| o_phi2 | output | 1 | Transfer phase 2 |
| o_hold | output | 1 | Last-stage hold clock |
| o_rst_pulse | output | 1 | Output reset clock |
| o_line_valid | output | 1 | High while pixels of the line are output |
| o_pix_idx | output | IDX_W | Current pixel number, 0 outside the line |

## Verification
A sequencer that loses its place shows up at the ports within one pixel period. A miscounted interval moves the gate fall or the first phase-1 fall by a measurable number of cycles. A wrong pixel counter shows up as a skipped index or a valid window of the wrong length. A phase counter error breaks the hold-to-reset spacing inside the first pixel. A lost or doubled pending start, or a release count that is not held for the line, only becomes visible one line later. The bench measures that as the spacing between gate pulses and the timing of each shutter fall.

// File: rtl/lccd_tg_pkg.sv
`timescale 1ns/1ps
package lccd_tg_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SETUP  = 3'd1,
      ST_GATE   = 3'd2,
      ST_SETTLE = 3'd3,
      ST_READ   = 3'd4,
      ST_DRAIN  = 3'd5
   } seq_state_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/lccd_tg_phase.sv
`timescale 1ns/1ps
module lccd_tg_phase #(
   parameter int PIX_CLKS = 200,
   parameter int RS_GAP   = 10,
   parameter int RS_HIGH  = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic i_run,
   output logic o_wrap,
   output logic o_phi1,
   output logic o_phi2,
   output logic o_hold,
   output logic o_rst_pulse
);
   localparam int PH_W   = $clog2(PIX_CLKS);
   localparam int HALF   = PIX_CLKS / 2;
   localparam int RS_ON  = HALF + RS_GAP;
   localparam int RS_OFF = RS_ON + RS_HIGH;

   logic [PH_W-1:0] ph;
   logic            last;

   assign last   = (ph == PH_W'(PIX_CLKS - 1));
   assign o_wrap = i_run && last;

   always_ff @(posedge clk) begin
      if (!rst_n)      ph <= '0;
      else if (!i_run) ph <= '0;
      else if (last)   ph <= '0;
      else             ph <= ph + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         o_phi1      <= 1'b1;
         o_phi2      <= 1'b0;
         o_hold      <= 1'b1;
         o_rst_pulse <= 1'b0;
      end else begin
         o_phi1      <= !i_run || (ph < PH_W'(HALF));
         o_phi2      <= i_run && (ph >= PH_W'(HALF));
         o_hold      <= !i_run || (ph < PH_W'(HALF));
         o_rst_pulse <= i_run && (ph >= PH_W'(RS_ON)) && (ph < PH_W'(RS_OFF));
      end
   end

   initial begin
      assert_pix_even_R4: assert (PIX_CLKS >= 4 && (PIX_CLKS % 2) == 0)
         else $error("pixel period must be even and at least 4");
      assert_rs_fit_R5: assert (RS_GAP >= 1 && RS_HIGH >= 1 && RS_OFF + RS_GAP <= PIX_CLKS)
         else $error("reset pulse does not fit in the low half of the hold clock");
   end

   assert_phase_compl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      o_phi1 != o_phi2);
   assert_rs_in_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      o_rst_pulse |-> !o_hold);
   assert_rs_after_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(o_rst_pulse) |-> !$past(o_hold));
   assert_idle_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !i_run |=> (o_phi1 && !o_rst_pulse));

endmodule

// File: rtl/lccd_tg_seq.sv
`timescale 1ns/1ps
module lccd_tg_seq
   import lccd_tg_pkg::*;
#(
   parameter int LINE_PIXELS = 10583,
   parameter int T_SETUP     = 20,
   parameter int T_GATE      = 600,
   parameter int T_SETTLE    = 600,
   parameter int NCOL        = 3,
   parameter int REL_W       = 16,
   parameter int IDX_W       = 14
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       i_start,
   input  logic [NCOL*REL_W-1:0]      i_release,
   input  logic                       i_wrap,
   output logic                       o_run,
   output logic                       o_gate_now,
   output logic                       o_span_now,
   output logic                       o_read_now,
   output logic                       o_drain_now,
   output logic [IDX_W-1:0]           o_pcnt,
   output logic [REL_W-1:0]           o_hcnt,
   output logic [NCOL-1:0][REL_W-1:0] o_rel_q
);
   localparam int TMAX = max3(T_SETUP, T_GATE, T_SETTLE);
   localparam int TC_W = $clog2(TMAX + 1);

   seq_state_e                 st, st_n;
   logic [TC_W-1:0]            tcnt, tcnt_n;
   logic [IDX_W-1:0]           pcnt, pcnt_n;
   logic [REL_W-1:0]           hcnt, hcnt_n;
   logic                       pend, pend_n;
   logic [NCOL-1:0][REL_W-1:0] rel_q;
   logic [REL_W-1:0]           maxrel;
   logic                       launch;

   always_comb begin
      maxrel = '0;
      for (int c = 0; c < NCOL; c++) begin
         if (rel_q[c] > maxrel) maxrel = rel_q[c];
      end
   end

   always_comb begin
      st_n   = st;
      pcnt_n = pcnt;
      hcnt_n = hcnt;
      case (st)
         ST_IDLE: begin
            if (i_start || pend) st_n = ST_SETUP;
         end
         ST_SETUP: begin
            if (tcnt == TC_W'(T_SETUP - 1)) st_n = ST_GATE;
         end
         ST_GATE: begin
            if (tcnt == TC_W'(T_GATE - 1)) st_n = ST_SETTLE;
         end
         ST_SETTLE: begin
            if (tcnt == TC_W'(T_SETTLE - 1)) begin
               st_n   = ST_READ;
               pcnt_n = IDX_W'(1);
            end
         end
         ST_READ: begin
            if (i_wrap) begin
               if (pcnt == IDX_W'(LINE_PIXELS)) begin
                  pcnt_n = '0;
                  hcnt_n = '0;
                  st_n   = (maxrel == '0) ? ST_IDLE : ST_DRAIN;
               end else begin
                  pcnt_n = pcnt + 1'b1;
               end
            end
         end
         ST_DRAIN: begin
            if (i_wrap) begin
               if (hcnt == maxrel - REL_W'(1)) begin
                  st_n   = ST_IDLE;
                  hcnt_n = '0;
               end else begin
                  hcnt_n = hcnt + 1'b1;
               end
            end
         end
         default: st_n = ST_IDLE;
      endcase
      tcnt_n = (st_n != st) ? '0 : tcnt + 1'b1;
      if (st == ST_IDLE) tcnt_n = '0;
   end

   assign launch = (st == ST_IDLE) && (st_n == ST_SETUP);

   always_comb begin
      if (st == ST_IDLE) pend_n = 1'b0;
      else if (i_start)  pend_n = 1'b1;
      else               pend_n = pend;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         tcnt <= '0;
         pcnt <= '0;
         hcnt <= '0;
         pend <= 1'b0;
      end else begin
         st   <= st_n;
         tcnt <= tcnt_n;
         pcnt <= pcnt_n;
         hcnt <= hcnt_n;
         pend <= pend_n;
      end
   end

   generate
      for (genvar c = 0; c < NCOL; c++) begin : g_rel
         always_ff @(posedge clk) begin
            if (!rst_n)      rel_q[c] <= '0;
            else if (launch) rel_q[c] <= i_release[c*REL_W +: REL_W];
         end
      end
   endgenerate

   assign o_run       = (st == ST_READ) || (st == ST_DRAIN);
   assign o_gate_now  = (st == ST_GATE);
   assign o_span_now  = (st == ST_GATE) || (st == ST_SETTLE) || (st == ST_READ);
   assign o_read_now  = (st == ST_READ);
   assign o_drain_now = (st == ST_DRAIN);
   assign o_pcnt      = pcnt;
   assign o_hcnt      = hcnt;
   assign o_rel_q     = rel_q;

   assert_pend_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE && i_start) |=> pend);
   assert_read_idx_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_READ) |-> (pcnt != '0 && pcnt <= IDX_W'(LINE_PIXELS)));
   assert_drain_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DRAIN) |-> (maxrel != '0));
   assert_rel_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE && $past(st) != ST_IDLE) |-> $stable(rel_q));

endmodule

// File: rtl/lccd_tg_shutter.sv
`timescale 1ns/1ps
module lccd_tg_shutter #(
   parameter int REL_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             i_span,
   input  logic             i_drain,
   input  logic [REL_W-1:0] i_hcnt,
   input  logic [REL_W-1:0] i_rel,
   output logic             o_shut
);
   always_ff @(posedge clk) begin
      if (!rst_n) o_shut <= 1'b0;
      else        o_shut <= i_span || (i_drain && (i_hcnt < i_rel));
   end

   assert_shut_span_R7: assert property (@(posedge clk) disable iff (!rst_n)
      i_span |=> o_shut);

endmodule

// File: rtl/lccd_timing_gen.sv
`timescale 1ns/1ps
module lccd_timing_gen #(
   parameter int SYS_NS      = 5,
   parameter int LINE_PIXELS = 10583,
   parameter int PIX_CLKS    = 200,
   parameter int T_SETUP     = 20,
   parameter int T_GATE      = 600,
   parameter int T_SETTLE    = 600,
   parameter int RS_GAP      = 10,
   parameter int RS_HIGH     = 20,
   parameter int NCOL        = 3,
   parameter int REL_W       = 16,
   localparam int IDX_W      = $clog2(LINE_PIXELS + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  i_start,
   input  logic [NCOL*REL_W-1:0] i_release,
   output logic [NCOL-1:0]       o_gate,
   output logic [NCOL-1:0]       o_shut,
   output logic                  o_phi1,
   output logic                  o_phi2,
   output logic                  o_hold,
   output logic                  o_rst_pulse,
   output logic                  o_line_valid,
   output logic [IDX_W-1:0]      o_pix_idx
);
   localparam int GL_W = $clog2(T_GATE + 2);

   logic                       run, wrap;
   logic                       gate_now, span_now, read_now, drain_now;
   logic [IDX_W-1:0]           pcnt;
   logic [REL_W-1:0]           hcnt;
   logic [NCOL-1:0][REL_W-1:0] rel_q;
   logic [GL_W-1:0]            gate_len;

   lccd_tg_seq #(
      .LINE_PIXELS(LINE_PIXELS), .T_SETUP(T_SETUP), .T_GATE(T_GATE),
      .T_SETTLE(T_SETTLE), .NCOL(NCOL), .REL_W(REL_W), .IDX_W(IDX_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .i_start(i_start), .i_release(i_release),
      .i_wrap(wrap), .o_run(run), .o_gate_now(gate_now), .o_span_now(span_now),
      .o_read_now(read_now), .o_drain_now(drain_now), .o_pcnt(pcnt),
      .o_hcnt(hcnt), .o_rel_q(rel_q)
   );

   lccd_tg_phase #(
      .PIX_CLKS(PIX_CLKS), .RS_GAP(RS_GAP), .RS_HIGH(RS_HIGH)
   ) u_phase (
      .clk(clk), .rst_n(rst_n), .i_run(run), .o_wrap(wrap),
      .o_phi1(o_phi1), .o_phi2(o_phi2), .o_hold(o_hold), .o_rst_pulse(o_rst_pulse)
   );

   generate
      for (genvar c = 0; c < NCOL; c++) begin : g_col
         always_ff @(posedge clk) begin
            if (!rst_n) o_gate[c] <= 1'b0;
            else        o_gate[c] <= gate_now;
         end
         lccd_tg_shutter #(.REL_W(REL_W)) u_shut (
            .clk(clk), .rst_n(rst_n), .i_span(span_now), .i_drain(drain_now),
            .i_hcnt(hcnt), .i_rel(rel_q[c]), .o_shut(o_shut[c])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         o_line_valid <= 1'b0;
         o_pix_idx    <= '0;
      end else begin
         o_line_valid <= read_now;
         o_pix_idx    <= read_now ? pcnt : '0;
      end
   end

   // gate-width checker counter
   always_ff @(posedge clk) begin
      if (!rst_n)         gate_len <= '0;
      else if (o_gate[0]) gate_len <= gate_len + 1'b1;
      else                gate_len <= '0;
   end

   initial begin
      assert_gate_min_R2: assert (T_GATE * SYS_NS >= 1200)
         else $error("readout gate shorter than sensor minimum");
      assert_setup_min_R3: assert (T_SETUP * SYS_NS >= 50)
         else $error("phase-1 to gate setup too short");
      assert_settle_min_R3: assert (T_SETTLE * SYS_NS >= 1200)
         else $error("gate to phase-1 settle too short");
      assert_rs_min_R5: assert (RS_GAP * SYS_NS >= 45 && RS_HIGH * SYS_NS >= 45)
         else $error("reset pulse width or offset too short");
      assert_rate_max_R4: assert (PIX_CLKS * SYS_NS >= 200)
         else $error("pixel rate above 5 MHz");
      assert_colours_R7: assert (NCOL >= 1 && REL_W >= 1 && LINE_PIXELS >= 2)
         else $error("bad colour or line configuration");
   end

   assert_gate_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(o_gate[0]) |-> (gate_len == GL_W'(T_GATE)));
   assert_gate_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      o_gate[0] |-> (o_phi1 && $stable(o_phi1)));
   assert_shut_cover_R7: assert property (@(posedge clk) disable iff (!rst_n)
      o_line_valid |-> (&o_shut));
   assert_valid_idx_R1: assert property (@(posedge clk) disable iff (!rst_n)
      o_line_valid |-> (o_pix_idx != '0));
   assert_idle_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !o_line_valid |-> (o_pix_idx == '0));

endmodule

// File: tb/lccd_timing_gen_test.sv
`timescale 1ns/1ps
module lccd_timing_gen_test;
   localparam int TS   = 10;
   localparam int TG   = 240;
   localparam int TT   = 240;
   localparam int PIX  = 60;
   localparam int HALF = 30;
   localparam int GAP  = 9;
   localparam int RSH  = 10;
   localparam int N    = 16;
   localparam int RW   = 4;
   localparam int LINE_WAIT = 2450;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [3*RW-1:0] rel = '0;
   logic [2:0]    gate, shut;
   logic          phi1, phi2, hold, rs, valid;
   logic [4:0]    idx;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   lccd_timing_gen #(
      .SYS_NS(5), .LINE_PIXELS(N), .PIX_CLKS(PIX), .T_SETUP(TS), .T_GATE(TG),
      .T_SETTLE(TT), .RS_GAP(GAP), .RS_HIGH(RSH), .NCOL(3), .REL_W(RW)
   ) uut (
      .clk(clk), .rst_n(rst_n), .i_start(start), .i_release(rel),
      .o_gate(gate), .o_shut(shut), .o_phi1(phi1), .o_phi2(phi2), .o_hold(hold),
      .o_rst_pulse(rs), .o_line_valid(valid), .o_pix_idx(idx)
   );

   // port monitor
   int cyc = 0;
   int gate_rises, t_gr, t_gf, t_p1f, t_vf, pix_cycles, rs_in_line, idx_err;
   int comp_err, rs_err, rs_seen, per_err, gate_mis, p1_in_line, t_pp1f;
   int t_hf, t_rsr, t_lsf, t_gap;
   int t_sf[3], t_sr[3];
   bit p1f_wait, phi1_at_gr;
   logic pg = 0, pv = 0, pp1 = 1, phold = 1, prs = 0;
   logic [2:0] ps = '0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (gate !== {3{gate[0]}}) gate_mis++;
         if (gate[0] && !pg) begin
            gate_rises++;
            if (gate_rises > 1) t_gap = cyc - t_lsf;
            t_gr = cyc;
            phi1_at_gr = phi1;
         end
         if (!gate[0] && pg) begin t_gf = cyc; p1f_wait = 1; end
         if (!phi1 && pp1) begin
            if (p1f_wait) begin t_p1f = cyc; p1f_wait = 0; end
            if (valid) begin
               p1_in_line++;
               if (p1_in_line > 1 && cyc - t_pp1f != PIX) per_err++;
               t_pp1f = cyc;
            end
         end
         if (valid && !pv) begin p1_in_line = 0; rs_in_line = 0; end
         if (!valid && pv) t_vf = cyc;
         if (valid) pix_cycles++;
         if (phi1 === phi2) comp_err++;
         if (hold !== phi1) comp_err++;
         if (!hold && phold) t_hf = cyc;
         if (rs && !prs) begin
            t_rsr = cyc;
            rs_seen++;
            if (cyc - t_hf != GAP) rs_err++;
            if (valid) begin
               rs_in_line++;
               if (int'(idx) != rs_in_line) idx_err++;
            end
         end
         if (!rs && prs && (cyc - t_rsr != RSH)) rs_err++;
         for (int c = 0; c < 3; c++) begin
            if (shut[c] && !ps[c]) t_sr[c] = cyc;
            if (!shut[c] && ps[c]) begin t_sf[c] = cyc; t_lsf = cyc; end
         end
      end
      pg = gate[0]; pv = valid; pp1 = phi1; phold = hold; prs = rs; ps = shut;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      gate_rises = 0; t_gr = 0; t_gf = 0; t_p1f = 0; t_vf = 0; pix_cycles = 0;
      rs_in_line = 0; idx_err = 0; comp_err = 0; rs_err = 0; rs_seen = 0;
      per_err = 0; gate_mis = 0; p1_in_line = 0; t_pp1f = 0; t_gap = 0;
      p1f_wait = 0; phi1_at_gr = 0;
      for (int c = 0; c < 3; c++) begin t_sf[c] = 0; t_sr[c] = 0; end
   endtask

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic check_idle(input string tag);
      chk(phi1 === 1'b1 && hold === 1'b1, {tag, " R9 phi1/hold idle high"}, int'(phi1), 1);
      chk(phi2 === 1'b0 && rs === 1'b0, {tag, " R9 phi2/reset idle low"}, int'(phi2), 0);
      chk(gate === 3'b0 && shut === 3'b0 && valid === 1'b0 && idx === 5'd0,
          {tag, " R9 gate/shutter/valid/index idle"}, int'({gate, shut}), 0);
   endtask

   task automatic check_line(input int r0, input int r1, input int r2);
      int rv[3];
      rv[0] = r0; rv[1] = r1; rv[2] = r2;
      chk(gate_rises == 1, "R2 one gate pulse per line", gate_rises, 1);
      chk(t_gf - t_gr == TG, "R2 gate width", t_gf - t_gr, TG);
      chk(gate_mis == 0, "R2 colour gates aligned", gate_mis, 0);
      chk(phi1_at_gr == 1, "R3 phi1 high at gate rise", int'(phi1_at_gr), 1);
      chk(t_p1f - t_gf == TT + HALF, "R3 gate fall to first phi1 fall", t_p1f - t_gf, TT + HALF);
      chk(pix_cycles == N * PIX, "R1 valid window length", pix_cycles, N * PIX);
      chk(p1_in_line == N, "R1 transfer periods per line", p1_in_line, N);
      chk(rs_in_line == N, "R1 reset pulses per line", rs_in_line, N);
      chk(idx_err == 0, "R1 pixel index sequence", idx_err, 0);
      chk(comp_err == 0, "R4 phase complement and hold", comp_err, 0);
      chk(per_err == 0, "R4 transfer period", per_err, 0);
      chk(rs_err == 0 && rs_seen > 0, "R5 reset pulse offset and width", rs_err, 0);
      for (int c = 0; c < 3; c++) begin
         chk(t_sr[c] == t_gr, "R7 shutter rises with gate", t_sr[c] - t_gr, 0);
         chk(t_sf[c] - t_vf == rv[c] * PIX, "R7 shutter release", t_sf[c] - t_vf, rv[c] * PIX);
      end
   endtask

   task automatic test_reset_idle();
      clear_mon();
      repeat (300) @(posedge clk);
      #1;
      check_idle("reset");
      chk(gate_rises == 0, "R9 no gate without start", gate_rises, 0);
   endtask

   task automatic test_line(input int r0, input int r1, input int r2);
      clear_mon();
      @(negedge clk) rel = {RW'(r2), RW'(r1), RW'(r0)};
      pulse_start();
      repeat (LINE_WAIT) @(posedge clk);
      #1;
      check_line(r0, r1, r2);
      check_idle("after line");
   endtask

   task automatic test_release_sampled();
      clear_mon();
      @(negedge clk) rel = {RW'(2), RW'(9), RW'(4)};
      pulse_start();
      repeat (TS + 40) @(posedge clk);
      @(negedge clk) rel = {RW'(1), RW'(1), RW'(1)};
      repeat (LINE_WAIT) @(posedge clk);
      #1;
      chk(t_sf[0] - t_vf == 4 * PIX, "R8 red release held", t_sf[0] - t_vf, 4 * PIX);
      chk(t_sf[1] - t_vf == 9 * PIX, "R8 green release held", t_sf[1] - t_vf, 9 * PIX);
      chk(t_sf[2] - t_vf == 2 * PIX, "R8 blue release held", t_sf[2] - t_vf, 2 * PIX);
   endtask

   task automatic test_pending();
      clear_mon();
      @(negedge clk) rel = {RW'(3), RW'(0), RW'(0)};
      pulse_start();
      repeat (TS + TG + TT + 3 * PIX) @(posedge clk);
      pulse_start();
      pulse_start();
      repeat (2 * LINE_WAIT) @(posedge clk);
      #1;
      chk(gate_rises == 2, "R6 one queued line", gate_rises, 2);
      chk(t_gap == TS + 1, "R6 queued line follows last shutter", t_gap, TS + 1);
      chk(t_sf[2] - t_vf == 3 * PIX, "R7 queued line release", t_sf[2] - t_vf, 3 * PIX);
      check_idle("after queue");
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      test_reset_idle();
      test_line(3, 0, 5);
      test_line(0, 15, 7);
      test_release_sampled();
      test_pending();
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(5.0 * 190000);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule